// File: doc/BRIEF.md
# Crowded Binary Tournament Selector

This block chooses one parent for reproduction in a hardware multi-objective evolutionary optimiser. On each accepted request it draws two contenders from the population using an external uniform random word. It reads each contender's front rank and crowding distance from the population memory through two read ports. It then reports the index of the contender that wins.

The winner is chosen by front rank first. Crowding distance only breaks ties between equal ranks. A full tie always goes to the first-drawn contender, so the result is deterministic for a given random word and memory content.

A tournament takes two cycles. In the first cycle the block issues the memory read. In the second cycle it compares the two records. The result is held until the consumer takes it. With a steady stream of requests and a consumer that is always ready, the block produces one winner every two cycles.

Top module: `crowd_tourney_sel`

## Requirements
- R1: In the cycle a request is accepted, `mem_rd_en_o` is high. Port A is addressed with `rnd_word_i[15:0]` modulo `POP_SIZE` and port B with `rnd_word_i[31:16]` modulo `POP_SIZE`. `mem_rd_en_o` is low in every other cycle.
- R2: When both reduced indices are equal, port B is addressed with the next index, wrapping from `POP_SIZE-1` to 0, so the two contenders always differ.
- R3: The contender with the numerically lower rank wins.
- R4: With equal ranks, the larger crowding distance wins. The all-ones distance stands for infinity and beats every finite distance.
- R5: With equal rank and equal distance, the port A contender wins.
- R6: `win_valid_o` rises two rising edges after the acceptance edge. `req_ready_o` is low in the cycle between them.
- R7: While `win_valid_o` is high and `win_ready_i` is low, `win_valid_o` and `win_idx_o` hold and no new request is accepted.
- R8: With `req_i` and `win_ready_i` held high, a request is accepted in the same cycle the previous winner is taken, giving one winner every two cycles.
- R9: During and after reset, `win_valid_o` and `mem_rd_en_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request a tournament |
| req_ready_o | output | 1 | Request is accepted when high together with req_i |
| rnd_word_i | input | RAND_W | Uniform random word, sampled on acceptance |
| mem_rd_en_o | output | 1 | Read enable for both memory ports |
| mem_addr_a_o | output | IDX_W | Index of the first contender |
| mem_addr_b_o | output | IDX_W | Index of the second contender |
| mem_rank_a_i | input | RANK_W | Rank of the first contender, one cycle after the read |
| mem_dist_a_i | input | DIST_W | Crowding distance of the first contender |
| mem_rank_b_i | input | RANK_W | Rank of the second contender |
| mem_dist_b_i | input | DIST_W | Crowding distance of the second contender |
| win_valid_o | output | 1 | Winner index is valid |
| win_idx_o | output | IDX_W | Winner index |
| win_ready_i | input | 1 | Consumer takes the winner |

## Verification
The bench first uses pairs that differ only in rank, in either order. These show whether rank alone decides and in which direction. Pairs of equal rank with differing distances, including infinite against near-infinite and infinite against infinite, separate the tie-break path from the rank path. Equal random halves, and halves that collide at the top index, expose a wrong or missing wrap in the second index. A stalled consumer and a continuous request stream separate correct holding and two-cycle throughput from lost or duplicated winners. A sweep over many random words and a varied memory pattern catches reduction and compare errors that the directed pairs miss.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CMP  = 1'b1
    } tsel_state_e;
endpackage

// File: rtl/tsel_index_gen.sv
`timescale 1ns/1ps
// Reduces the halves of a random word into two distinct population indices.
module tsel_index_gen #(
    parameter int POP_SIZE = 100,
    parameter int RAND_W   = 32,
    parameter int IDX_W    = 7
) (
    input  logic [RAND_W-1:0] rnd_i,
    output logic [IDX_W-1:0]  idx_a_o,
    output logic [IDX_W-1:0]  idx_b_o
);
    localparam int HALF_W = RAND_W / 2;
    localparam logic [HALF_W-1:0] POP_H  = HALF_W'(POP_SIZE);
    localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(POP_SIZE - 1);

    logic [HALF_W-1:0] red_a;
    logic [HALF_W-1:0] red_b;
    logic [IDX_W-1:0]  raw_b;

    always_comb begin
        red_a   = rnd_i[HALF_W-1:0] % POP_H;
        red_b   = rnd_i[RAND_W-1:HALF_W] % POP_H;
        idx_a_o = IDX_W'(red_a);
        raw_b   = IDX_W'(red_b);
        if (raw_b == idx_a_o) begin
            idx_b_o = (raw_b == LAST_I) ? '0 : raw_b + IDX_W'(1);
        end else begin
            idx_b_o = raw_b;
        end
    end
endmodule

// File: rtl/tsel_compare.sv
`timescale 1ns/1ps
// Decides whether contender B beats contender A: rank first, distance second.
module tsel_compare #(
    parameter int RANK_W = 8,
    parameter int DIST_W = 16
) (
    input  logic [RANK_W-1:0] rank_a_i,
    input  logic [DIST_W-1:0] dist_a_i,
    input  logic [RANK_W-1:0] rank_b_i,
    input  logic [DIST_W-1:0] dist_b_i,
    output logic              pick_b_o
);
    logic rank_b_better;
    logic rank_same;
    logic dist_b_wider;

    always_comb begin
        rank_b_better = rank_b_i < rank_a_i;
        rank_same     = rank_b_i == rank_a_i;
        // all-ones is the largest unsigned value, so infinity wins naturally
        dist_b_wider  = dist_b_i > dist_a_i;
        pick_b_o      = rank_b_better || (rank_same && dist_b_wider);
    end
endmodule

// File: rtl/crowd_tourney_sel.sv
`timescale 1ns/1ps
module crowd_tourney_sel #(
    parameter int POP_SIZE = 100,
    parameter int RAND_W   = 32,
    parameter int RANK_W   = 8,
    parameter int DIST_W   = 16,
    parameter int IDX_W    = $clog2(POP_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              req_ready_o,
    input  logic [RAND_W-1:0] rnd_word_i,
    output logic              mem_rd_en_o,
    output logic [IDX_W-1:0]  mem_addr_a_o,
    output logic [IDX_W-1:0]  mem_addr_b_o,
    input  logic [RANK_W-1:0] mem_rank_a_i,
    input  logic [DIST_W-1:0] mem_dist_a_i,
    input  logic [RANK_W-1:0] mem_rank_b_i,
    input  logic [DIST_W-1:0] mem_dist_b_i,
    output logic              win_valid_o,
    output logic [IDX_W-1:0]  win_idx_o,
    input  logic              win_ready_i
);
    import tsel_pkg::*;

    typedef struct packed {
        tsel_state_e      st;
        logic             vld;
        logic [IDX_W-1:0] ia;
        logic [IDX_W-1:0] ib;
        logic [IDX_W-1:0] win;
    } sel_regs_t;

    sel_regs_t        r_q, r_d;
    logic [IDX_W-1:0] draw_a, draw_b;
    logic             pick_b;
    logic             slot_free;
    logic             accept;

    tsel_index_gen #(
        .POP_SIZE (POP_SIZE),
        .RAND_W   (RAND_W),
        .IDX_W    (IDX_W)
    ) u_idx (
        .rnd_i   (rnd_word_i),
        .idx_a_o (draw_a),
        .idx_b_o (draw_b)
    );

    tsel_compare #(
        .RANK_W (RANK_W),
        .DIST_W (DIST_W)
    ) u_cmp (
        .rank_a_i (mem_rank_a_i),
        .dist_a_i (mem_dist_a_i),
        .rank_b_i (mem_rank_b_i),
        .dist_b_i (mem_dist_b_i),
        .pick_b_o (pick_b)
    );

    always_comb begin
        r_d       = r_q;
        slot_free = (r_q.st == ST_IDLE) && (!r_q.vld || win_ready_i);
        accept    = slot_free && req_i;
        if (r_q.vld && win_ready_i) begin
            r_d.vld = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st = ST_CMP;
                    r_d.ia = draw_a;
                    r_d.ib = draw_b;
                end
            end
            ST_CMP: begin
                r_d.st  = ST_IDLE;
                r_d.vld = 1'b1;
                r_d.win = pick_b ? r_q.ib : r_q.ia;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, vld: 1'b0, ia: '0, ib: '0, win: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o  = slot_free;
    assign mem_rd_en_o  = accept;
    assign mem_addr_a_o = draw_a;
    assign mem_addr_b_o = draw_b;
    assign win_valid_o  = r_q.vld;
    assign win_idx_o    = r_q.win;
endmodule

// File: rtl/tsel_checker.sv
`timescale 1ns/1ps
module tsel_checker #(
    parameter int POP_SIZE = 100,
    parameter int IDX_W    = $clog2(POP_SIZE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             req_ready_o,
    input logic             mem_rd_en_o,
    input logic [IDX_W-1:0] mem_addr_a_o,
    input logic [IDX_W-1:0] mem_addr_b_o,
    input logic             win_valid_o,
    input logic [IDX_W-1:0] win_idx_o,
    input logic             win_ready_i
);
    // R1: issued addresses stay inside the population
    a_r1_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (int'(mem_addr_a_o) < POP_SIZE && int'(mem_addr_b_o) < POP_SIZE));

    // R2: the two contenders are always distinct
    a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> mem_addr_a_o != mem_addr_b_o);

    // R6: result follows two edges after acceptance, not ready in between
    a_r6_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> (!req_ready_o ##1 win_valid_o));

    // R7: a stalled result holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && !win_ready_i) |=> (win_valid_o && $stable(win_idx_o)));

    // R7: nothing accepted over a stalled result
    a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && !win_ready_i) |-> !mem_rd_en_o);

    // R3: the winner is one of the two drawn contenders
    a_r3_winner_drawn: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_en_o, 2) |->
            (win_idx_o == $past(mem_addr_a_o, 2) || win_idx_o == $past(mem_addr_b_o, 2)));

    // R1: a read is only issued for a request
    a_r1_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (req_i && req_ready_o));
endmodule

bind crowd_tourney_sel tsel_checker #(.POP_SIZE(POP_SIZE)) u_chk (.*);

// File: tb/crowd_tourney_sel_tb.sv
`timescale 1ns/1ps
module crowd_tourney_sel_tb;
    localparam int POP   = 100;
    localparam int IDX_W = $clog2(POP);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              req_ready_o;
    logic [31:0]       rnd_word_i = '0;
    logic              mem_rd_en_o;
    logic [IDX_W-1:0]  mem_addr_a_o, mem_addr_b_o;
    logic [7:0]        mem_rank_a_i, mem_rank_b_i;
    logic [15:0]       mem_dist_a_i, mem_dist_b_i;
    logic              win_valid_o;
    logic [IDX_W-1:0]  win_idx_o;
    logic              win_ready_i = 1'b0;

    logic [7:0]  rk [POP];
    logic [15:0] ds [POP];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    crowd_tourney_sel u_dut (.*);

    // synchronous two-port population memory model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en_o) begin
            mem_rank_a_i <= rk[mem_addr_a_o];
            mem_dist_a_i <= ds[mem_addr_a_o];
            mem_rank_b_i <= rk[mem_addr_b_o];
            mem_dist_b_i <= ds[mem_addr_b_o];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void draw(input logic [31:0] r, output int a, output int b);
        a = int'(r[15:0]) % POP;
        b = int'(r[31:16]) % POP;
        if (b == a) b = (a + 1) % POP;
    endfunction

    function automatic int expect_win(input int a, input int b);
        if (rk[a] != rk[b]) return (rk[a] < rk[b]) ? a : b;
        if (ds[a] != ds[b]) return (ds[a] > ds[b]) ? a : b;
        return a;
    endfunction

    task automatic tourney(input logic [31:0] r, input string tag);
        int ea, eb, ew;
        draw(r, ea, eb);
        ew = expect_win(ea, eb);
        @(negedge clk);
        req_i = 1'b1; rnd_word_i = r;
        #0.5;
        chk(mem_rd_en_o == 1'b1, {"R1 rd_en ", tag}, mem_rd_en_o, 1);
        chk(int'(mem_addr_a_o) == ea, {"R1 addr_a ", tag}, mem_addr_a_o, ea);
        chk(int'(mem_addr_b_o) == eb, {"R2 addr_b ", tag}, mem_addr_b_o, eb);
        @(negedge clk);
        req_i = 1'b0;
        chk(!win_valid_o && !req_ready_o, {"R6 mid ", tag}, win_valid_o, 0);
        @(negedge clk);
        chk(win_valid_o == 1'b1, {"R6 valid ", tag}, win_valid_o, 1);
        chk(int'(win_idx_o) == ew, {"R3/R4/R5 winner ", tag}, win_idx_o, ew);
        win_ready_i = 1'b1;
        @(negedge clk);
        win_ready_i = 1'b0;
        chk(!win_valid_o, {"R7 taken ", tag}, win_valid_o, 0);
    endtask

    task automatic set_pair(input int a, input int ra, input int da, input int b, input int rb, input int db);
        rk[a] = 8'(ra); ds[a] = 16'(da);
        rk[b] = 8'(rb); ds[b] = 16'(db);
    endtask

    task automatic t_reset;
        #0.5;
        chk(!win_valid_o, "R9 valid in reset", win_valid_o, 0);
        chk(!mem_rd_en_o, "R9 rd_en in reset", mem_rd_en_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o, "R9 ready after reset", req_ready_o, 1);
        chk(!win_valid_o, "R9 valid after reset", win_valid_o, 0);
    endtask

    task automatic t_rank;
        set_pair(3, 2, 10, 7, 1, 0);            // R3: B lower rank
        tourney({16'd7, 16'd3}, "R3 b better");
        set_pair(3, 0, 0, 7, 4, 500);           // R3: A lower rank despite distance
        tourney({16'd7, 16'd3}, "R3 a better");
    endtask

    task automatic t_dist;
        set_pair(10, 1, 20, 20, 1, 30);         // R4
        tourney({16'd20, 16'd10}, "R4 b wider");
        set_pair(10, 1, 16'hFFFF, 20, 1, 16'hFFFE);
        tourney({16'd20, 16'd10}, "R4 a infinite");
        set_pair(10, 1, 16'hFFFE, 20, 1, 16'hFFFF);
        tourney({16'd20, 16'd10}, "R4 b infinite");
    endtask

    task automatic t_tie;
        set_pair(40, 3, 77, 50, 3, 77);         // R5
        tourney({16'd50, 16'd40}, "R5 full tie");
        set_pair(40, 3, 16'hFFFF, 50, 3, 16'hFFFF);
        tourney({16'd50, 16'd40}, "R5 both infinite");
    endtask

    task automatic t_same;
        tourney({16'd105, 16'd5}, "R2 equal draw");
        tourney({16'd199, 16'd99}, "R2 wrap to zero");
        tourney({16'hFFFF, 16'hFFFF}, "R1 large halves");
    endtask

    task automatic t_stall;
        int ea, eb, ew;
        draw(32'h0021_0042, ea, eb);
        ew = expect_win(ea, eb);
        @(negedge clk); req_i = 1'b1; rnd_word_i = 32'h0021_0042;
        @(negedge clk); req_i = 1'b0;
        @(negedge clk);
        req_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #0.5;
            chk(win_valid_o && int'(win_idx_o) == ew, "R7 held", win_idx_o, ew);
            chk(!mem_rd_en_o && !req_ready_o, "R7 no accept", mem_rd_en_o, 0);
            @(negedge clk);
        end
        req_i = 1'b0; win_ready_i = 1'b1;
        @(negedge clk); win_ready_i = 1'b0;
        chk(!win_valid_o, "R7 released", win_valid_o, 0);
    endtask

    task automatic t_stream;
        int exp_q[$];
        logic [31:0] r;
        int ea, eb;
        win_ready_i = 1'b1;
        r = 32'h1357_2468;
        for (int k = 0; k <= 12; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk(win_valid_o && int'(win_idx_o) == exp_q[0], "R8 stream winner", win_idx_o, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (k < 12) begin
                r = r * 32'd1664525 + 32'd1013904223;
                draw(r, ea, eb);
                exp_q.push_back(expect_win(ea, eb));
                req_i = 1'b1; rnd_word_i = r;
                #0.5;
                chk(mem_rd_en_o, "R8 accept with take", mem_rd_en_o, 1);
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
            chk(!mem_rd_en_o, "R6 compare cycle", mem_rd_en_o, 0);
        end
        win_ready_i = 1'b0;
        req_i = 1'b0;
    endtask

    task automatic t_sweep;
        logic [31:0] r = 32'hACE1_2357;
        for (int i = 0; i < POP; i++) begin
            rk[i] = 8'((i * 7) % 5);
            ds[i] = (i % 13 == 0) ? 16'hFFFF : 16'((i * 37) % 61);
        end
        for (int k = 0; k < 40; k++) begin
            r = r * 32'd22695477 + 32'd1;
            tourney(r, "R3 sweep");
        end
    endtask

    initial begin
        for (int i = 0; i < POP; i++) begin
            rk[i] = 8'd9; ds[i] = 16'd0;
        end
        t_reset();
        t_rank();
        t_dist();
        t_tie();
        t_same();
        t_stall();
        t_stream();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule